// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block supervises an 8-bit controller core. A free-running timer advances once per machine cycle, which is a fixed division of the oscillator. A software-selected power-of-two prescaler then slows the timer further. When the timer wraps around and supervision is armed, the block drives a reset pulse toward the system reset generator. Software must keep restarting the timer through a self-clearing clear bit, or the reset fires.

All configuration sits in one byte-wide register written and read through a simple strobe port. The core's idle state gates the timer unless software has allowed counting in idle. The reset pulse lasts a set number of clocks. While it is active, the block holds its own state at the reset defaults, and it comes out of the pulse disarmed.

Top module: `wdog_top`

## Requirements
- R1: After `rst`, the register reads 0x00, `wdt_rst` is low, and no reset pulse follows while software leaves the block unconfigured.
- R2: Register bit positions: bit 7 arms the reset, bit 6 is the clear request, bit 5 allows counting in idle, and bits 2..0 are the prescaler code. Bits 4 and 3 always read 0.
- R3: A written clear request reads back as 1 until the next machine-cycle tick, which is at most BASE_DIV oscillator ticks away. At that tick the request drops to 0, and the timer and prescaler restart from zero, so a full timeout period starts again.
- R4: With the timer armed, one timeout period is 2^CNT_W × P × BASE_DIV oscillator ticks. The prescaler divide P comes from the code: 000→2, 010→4, 001→8, 011→16, 100→32, 101→64, 110→128, 111→256.
- R5: When the arm bit is 0, the timer still runs and wraps, but `wdt_rst` stays low. Setting the arm bit later, without a clear, fires at the next wrap of the running timer.
- R6: While `idle` is high and bit 5 is 0, the timer and prescaler hold their values. When bit 5 is 1, counting goes on through idle.
- R7: A timeout raises `wdt_rst` for exactly RST_LEN clocks. When it drops, the register reads 0x00 and the block stays disarmed.
- R8: A write that changes the prescaler code restarts only the prescaler. The timer keeps its count.
- R9: The block advances only on clocks where `osc_en` is high, so halving the `osc_en` rate doubles the timeout period.
- R10: Register writes that arrive while `wdt_rst` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One pulse per oscillator period |
| idle | input | 1 | Core is in idle state |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| wdt_rst | output | 1 | Reset pulse toward the system reset generator |

## Verification
The hardest case to reach is a prescaler change partway through a timeout. The bench needs the timer already partly advanced, so it can show that only the prescaler restarted. To get there, the bench clears the timer on a slow prescaler code and waits a fixed number of cycles until the timer is roughly half full. It then writes a faster code without a clear. The remaining time to the pulse separates three cases: the timer was kept, the timer was wrongly reset, or the prescaler carried a stale count. The idle hold is reached the same way: the clear is issued while idle is already high, and the timeout is timed from the release of idle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // widest prescaler divide is 2^8
  localparam int PRE_W = 8;

  typedef struct packed {
    logic       en;
    logic       clr;
    logic       idle_run;
    logic [2:0] ps;
  } ctl_t;

  // log2 of the prescaler divide; the low half of the code has its two
  // lower bits swapped relative to the divide order
  function automatic logic [3:0] ps_exp(input logic [2:0] sel);
    if (sel[2]) return 4'd5 + {2'b00, sel[1:0]};
    else        return 4'd1 + {2'b00, sel[0], sel[1]};
  endfunction

endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       base_tick,
  output ctl_t       cfg,
  output logic       restart,
  output logic [7:0] rd_data
);

  logic [1:0] unused_gap;
  assign unused_gap = wr_data[4:3];

  // a new prescaler code restarts only the prescaler
  assign restart = wr_en && (wr_data[2:0] != cfg.ps);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr_en) begin
      cfg.en       <= wr_data[7];
      cfg.clr      <= wr_data[6];
      cfg.idle_run <= wr_data[5];
      cfg.ps       <= wr_data[2:0];
    end else if (cfg.clr && base_tick) begin
      cfg.clr <= 1'b0;
    end
  end

  assign rd_data = {cfg.en, cfg.clr, cfg.idle_run, 2'b00, cfg.ps};

  // R3: a pending clear is dropped at the machine-cycle tick
  p_clr_drop_r3: assert property (@(posedge clk) disable iff (rst)
    cfg.clr && base_tick && !wr_en |=> !cfg.clr);

endmodule

// File: rtl/wdog_div.sv
module wdog_div
  import wdog_pkg::*;
#(
  parameter int BASE_DIV = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       osc_en,
  input  logic       run,
  input  logic       clr_go,
  input  logic       restart,
  input  logic [2:0] ps,
  output logic       base_tick,
  output logic       pre_tick
);

  localparam int BASE_W = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;

  generate
    if (BASE_DIV > 1) begin : g_base
      localparam logic [BASE_W-1:0] LAST = BASE_W'(BASE_DIV - 1);
      logic [BASE_W-1:0] base_q;
      always_ff @(posedge clk) begin
        if (rst)          base_q <= '0;
        else if (osc_en)  base_q <= (base_q == LAST) ? '0 : base_q + 1'b1;
      end
      assign base_tick = osc_en && (base_q == LAST);
    end else begin : g_nobase
      assign base_tick = osc_en;
    end
  endgenerate

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim_m1;
  logic             run_tick;

  assign lim_m1   = ~({PRE_W{1'b1}} << ps_exp(ps));
  assign run_tick = base_tick && run;
  assign pre_tick = run_tick && (pre_q == lim_m1) && !clr_go;

  always_ff @(posedge clk) begin
    if (rst || clr_go || restart) pre_q <= '0;
    else if (run_tick)            pre_q <= (pre_q == lim_m1) ? '0 : pre_q + 1'b1;
  end

  // R4: the prescaler never runs past the selected divide
  p_pre_bound_r4: assert property (@(posedge clk) disable iff (rst)
    pre_q <= lim_m1);

  // R6: gated off in idle, the prescaler holds
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !run && !clr_go && !restart |=> $stable(pre_q));

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CNT_W   = 14,
  parameter int RST_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic blk_rst,
  input  logic pre_tick,
  input  logic clr_go,
  input  logic en,
  output logic wdt_rst
);

  localparam int RCNT_W = $clog2(RST_LEN + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [RCNT_W-1:0] rcnt_q;
  logic              wrap;

  assign wrap = pre_tick && (&cnt_q);

  always_ff @(posedge clk) begin
    if (blk_rst || clr_go) cnt_q <= '0;
    else if (pre_tick)     cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wdt_rst <= 1'b0;
      rcnt_q  <= '0;
    end else if (wdt_rst) begin
      if (rcnt_q == '0) wdt_rst <= 1'b0;
      else              rcnt_q  <= rcnt_q - 1'b1;
    end else if (wrap && en) begin
      wdt_rst <= 1'b1;
      rcnt_q  <= RCNT_W'(RST_LEN - 1);
    end
  end

  // R4: an armed wrap raises the pulse on the next cycle
  p_wrap_fires_r4: assert property (@(posedge clk) disable iff (rst)
    en && wrap && !wdt_rst && !blk_rst |=> wdt_rst);

  // R7: the pulse holds while its length counter is nonzero
  p_pulse_hold_r7: assert property (@(posedge clk) disable iff (rst)
    wdt_rst && (rcnt_q != '0) |=> wdt_rst);

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int BASE_DIV = 12,
  parameter int CNT_W    = 14,
  parameter int RST_LEN  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       osc_en,
  input  logic       idle,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       wdt_rst
);

  ctl_t cfg;
  logic restart, base_tick, pre_tick, clr_go, run, blk_rst;

  // the pulse holds the block at its defaults
  assign blk_rst = rst || wdt_rst;
  assign run     = !idle || cfg.idle_run;
  assign clr_go  = cfg.clr && base_tick;

  wdog_ctrl u_ctrl (
    .clk(clk), .rst(blk_rst), .wr_en(wr_en), .wr_data(wr_data),
    .base_tick(base_tick), .cfg(cfg), .restart(restart), .rd_data(rd_data)
  );

  wdog_div #(.BASE_DIV(BASE_DIV)) u_div (
    .clk(clk), .rst(blk_rst), .osc_en(osc_en), .run(run), .clr_go(clr_go),
    .restart(restart), .ps(cfg.ps), .base_tick(base_tick), .pre_tick(pre_tick)
  );

  wdog_count #(.CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_cnt (
    .clk(clk), .rst(rst), .blk_rst(blk_rst), .pre_tick(pre_tick),
    .clr_go(clr_go), .en(cfg.en), .wdt_rst(wdt_rst)
  );

  // R5: disarmed, no pulse can start
  p_quiet_disarmed_r5: assert property (@(posedge clk) disable iff (rst)
    !cfg.en && !wdt_rst |=> !wdt_rst);

  // R7: the register is back at defaults once the pulse ends
  p_defaults_after_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(wdt_rst) |-> rd_data == 8'h00);

endmodule

// File: tb/wdog_top_tb.sv
module wdog_top_tb;
  localparam int B  = 3;
  localparam int W  = 4;
  localparam int RL = 4;
  localparam int M  = 1 << W;

  logic       clk = 1'b0, rst = 1'b1, osc_en = 1'b1, idle = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       wdt_rst;
  logic       gate_osc = 1'b0;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  initial forever begin
    @(negedge clk);
    osc_en = gate_osc ? ~osc_en : 1'b1;
  end

  wdog_top #(.BASE_DIV(B), .CNT_W(W), .RST_LEN(RL)) u_dut (
    .clk(clk), .rst(rst), .osc_en(osc_en), .idle(idle), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .wdt_rst(wdt_rst)
  );

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_rise(output int n, input int lim);
    n = 0;
    while (n < lim) begin
      @(posedge clk); #1; n++;
      if (wdt_rst) return;
    end
    n = lim + 1;
  endtask

  task automatic drain();
    while (wdt_rst) begin @(posedge clk); #1; end
    @(negedge clk);
  endtask

  task automatic t_reset();
    int n;
    chk_eq("R1 rd_data", rd_data, 0);
    chk_eq("R1 wdt_rst", wdt_rst, 0);
    wait_rise(n, 200);
    chk_eq("R1 no pulse", n, 201);
  endtask

  task automatic t_layout();
    wr(8'h3D);
    chk_eq("R2 layout", rd_data, 8'h25);
    wr(8'h00);
  endtask

  task automatic t_clear();
    int n;
    wr(8'h40);
    chk_eq("R3 clr pending", rd_data, 8'h40);
    repeat (B) @(negedge clk);
    chk_eq("R3 clr dropped", rd_data, 8'h00);
    wr(8'hC0);
    repeat (60) @(negedge clk);
    wr(8'hC0);
    wait_rise(n, 300);
    chk_rng("R3 restart", n, 3*M*2 + 1, 3*M*2 + 3);
    drain();
  endtask

  task automatic t_period(input logic [2:0] ps, input int p);
    int n;
    wr({5'b11000, ps});
    wait_rise(n, 3*M*p + 20);
    chk_rng($sformatf("R4 period code %0d", ps), n, 3*M*p + 1, 3*M*p + 3);
    drain();
  endtask

  task automatic t_pulse();
    int n, len;
    wr(8'hC0);
    wait_rise(n, 300);
    len = 1;
    forever begin
      @(posedge clk); #1;
      if (wdt_rst) len++; else break;
    end
    chk_eq("R7 pulse length", len, RL);
    chk_eq("R7 defaults", rd_data, 0);
    wait_rise(n, 400);
    chk_eq("R7 stays disarmed", n, 401);
  endtask

  task automatic t_wr_pulse();
    int n;
    wr(8'hC0);
    wait_rise(n, 300);
    wr(8'hA3);
    drain();
    chk_eq("R10 write ignored", rd_data, 0);
  endtask

  task automatic t_disarmed();
    int n;
    wr(8'h40);
    wait_rise(n, 400);
    chk_eq("R5 no pulse", n, 401);
    wr(8'h80);
    wait_rise(n, 150);
    chk_rng("R5 late arm", n, 1, 100);
    drain();
  endtask

  task automatic t_idle();
    int n;
    @(negedge clk); idle = 1'b1;
    wr(8'hC0);
    wait_rise(n, 500);
    chk_eq("R6 idle hold", n, 501);
    @(negedge clk); idle = 1'b0;
    wait_rise(n, 200);
    chk_rng("R6 resume", n, 3*M*2 - 2, 3*M*2);
    drain();
    idle = 1'b1;
    wr(8'hE0);
    wait_rise(n, 300);
    chk_rng("R6 idle run", n, 3*M*2 + 1, 3*M*2 + 3);
    drain();
    idle = 1'b0;
  endtask

  task automatic t_ps_change();
    int n;
    wr(8'hC1);
    repeat (193) @(posedge clk);
    wr(8'h80);
    wait_rise(n, 200);
    chk_rng("R8 count kept", n, 38, 60);
    drain();
  endtask

  task automatic t_osc();
    int n;
    gate_osc = 1'b1;
    wr(8'hC0);
    wait_rise(n, 400);
    chk_rng("R9 half rate", n, 6*M*2 - 2, 6*M*2 + 8);
    gate_osc = 1'b0;
    drain();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_layout();
    t_clear();
    t_period(3'b000, 2);
    t_period(3'b010, 4);
    t_period(3'b001, 8);
    t_period(3'b011, 16);
    t_period(3'b100, 32);
    t_period(3'b111, 256);
    t_pulse();
    t_wr_pulse();
    t_disarmed();
    t_idle();
    t_ps_change();
    t_osc();
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

endmodule